// File: doc/BRIEF.md
# Accumulator CPU Control Unit

This block is the control unit of an accumulator CPU with separate instruction and data memories. Each cycle it takes one instruction word: an 8-bit opcode field above a 32-bit operand. It decodes the word into a command for the arithmetic unit, selects for the register array, a data-memory address with read and write strobes, and flag-clear strobes. It also owns the program counter and an upward-growing stack pointer. The accumulator, the flags, the register array and both memories are outside the block. The accumulator value and the four condition flags arrive as inputs.

Only the low six bits of the opcode field select the instruction. The program counter advances by one by default. It can also jump to the operand, jump only when a chosen flag is set, add the operand as an offset, load from the accumulator or hold for a halt. Push and pop use a stack that starts at data address 0. Guards stop the stack pointer from wrapping in either direction.

Top module: `acc_ctrl_unit`

## Requirements
- R1: While rst_n is low, pc_o and sp_o are 0.
- R2: Opcode bits 7:6 have no effect. Any 6-bit code not listed in R3 to R14 acts as a no-operation: alu_op_o is 15 (hold), every write and read strobe is 0, and the PC advances by one.
- R3: The arithmetic and logic codes drive alu_op_o and alu_src_o and raise acc_we_o. alu_op_o: 0 pass, 1 add, 2 sub, 3 and, 4 or, 5 xor, 6 not, 7 negate, 8 arithmetic right, 9 arithmetic left, 10 logical right, 11 logical left, 12 rotate right through carry, 13 rotate left through carry, 14 clear, 15 hold, 16 increment, 17 decrement. alu_src_o: 0 none, 1 register, 2 memory, 3 operand, 4 PC. The codes are: add 0x00/0x01/0x02 and sub 0x03/0x04/0x05 from register/memory/operand; 0x06 increment; 0x07 decrement; 0x08 arithmetic right; 0x09 arithmetic left; 0x0A logical left; 0x0B logical right; 0x0C rotate right; 0x0D rotate left; 0x0E/0x0F/0x10 and/or/xor with a register; 0x11 not; 0x12 negate; 0x1C clear.
- R4: For register-sourced codes (0x00, 0x03, 0x0E, 0x0F, 0x10, 0x23), reg_rd_sel_o is operand bits 2:0; otherwise it is 0. The register-write codes raise reg_we_o. Code 0x21 writes R0 from the operand (reg_wr_src_o 1). Code 0x22 writes R0 from memory (reg_wr_src_o 2). Code 0x24 writes R(operand bits 2:0) from the accumulator (reg_wr_src_o 0).
- R5: Memory reads raise mem_re_o. The address is the operand for 0x01, 0x04, 0x1F and 0x22. It is the accumulator for 0x25. Codes 0x1F, 0x23 and 0x25 load the accumulator with alu_op_o 0. When no memory access is made, mem_addr_o is 0.
- R6: mem_we_o is raised only by a store (0x20, address = operand) or by a push that is not refused. mem_we_o and mem_re_o are never high together.
- R7: The PC moves to the operand on 0x13. On 0x17 it moves to PC + operand, modulo 2^PC_W. Every other code not covered by R8 to R10 moves the PC to PC + 1, wrapping.
- R8: Codes 0x14, 0x15, 0x16 and 0x18 jump to the operand when Z, OV, C or EQ respectively is set. When that flag is clear, they advance by one.
- R9: Code 0x1D loads the PC from the accumulator. Code 0x1E writes the accumulator with alu_src_o 4 (PC) and alu_op_o 0.
- R10: Code 0x3F (halt) holds the PC at its current value.
- R11: Push (0x3C) writes at address SP and then increments SP.
- R12: Pop (0x3D) reads at address SP-1 into the accumulator (alu_op_o 0, alu_src_o 2) and then decrements SP.
- R13: A push when SP is all ones, or a pop when SP is 0, raises stack_err_o and leaves SP unchanged. It makes no memory access and no accumulator write, and mem_addr_o is 0.
- R14: Codes 0x19, 0x1A and 0x1B raise flag_clr_o bit 0 (Z), bit 1 (OV) and bit 2 (C) respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | OPND_W+8 | Opcode field above the operand |
| flag_z_i | input | 1 | Zero flag |
| flag_ov_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| flag_eq_i | input | 1 | Equal flag |
| acc_i | input | ACC_W | Accumulator value |
| pc_o | output | PC_W | Program counter |
| alu_op_o | output | 5 | Arithmetic unit operation |
| alu_src_o | output | 3 | Accumulator operand source |
| acc_we_o | output | 1 | Accumulator write enable |
| reg_rd_sel_o | output | 3 | Register read select |
| reg_we_o | output | 1 | Register write enable |
| reg_wr_sel_o | output | 3 | Register write select |
| reg_wr_src_o | output | 2 | Register write source |
| flag_clr_o | output | 3 | Flag clear strobes {C, OV, Z} |
| mem_addr_o | output | DA_W | Data memory address |
| mem_re_o | output | 1 | Data memory read |
| mem_we_o | output | 1 | Data memory write |
| sp_o | output | SP_W | Stack pointer |
| stack_err_o | output | 1 | Refused push or pop |

## Verification
The assertions check on every cycle that:
- halt, absolute jump, untaken branch and accumulator loads land the PC where expected one edge later;
- an accepted push or pop moves SP by exactly one;
- a refused one leaves SP unchanged and suppresses all writes;
- the two memory strobes never coincide.

Only the bench's scenarios can show the full decode table. This covers the ignored reserved bits, the register and address selection per code, the taken branches on each flag, and relative wrap-around. It also covers SP reaching and staying at both of its bounds across long push and pop runs.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

  localparam int OPC_W   = 8;
  localparam int CODE_W  = 6;
  localparam int RSEL_W  = 3;

  typedef enum logic [4:0] {
    ALU_PASS = 5'd0,  ALU_ADD = 5'd1,  ALU_SUB = 5'd2,  ALU_AND = 5'd3,
    ALU_OR   = 5'd4,  ALU_XOR = 5'd5,  ALU_NOT = 5'd6,  ALU_NEG = 5'd7,
    ALU_SRA  = 5'd8,  ALU_SLA = 5'd9,  ALU_SRL = 5'd10, ALU_SLL = 5'd11,
    ALU_RRC  = 5'd12, ALU_RLC = 5'd13, ALU_CLR = 5'd14, ALU_HOLD = 5'd15,
    ALU_INC  = 5'd16, ALU_DEC = 5'd17
  } alu_op_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0, SRC_REG = 3'd1, SRC_MEM = 3'd2, SRC_IMM = 3'd3, SRC_PC = 3'd4
  } alu_src_e;

  typedef enum logic [1:0] {RWS_ACC = 2'd0, RWS_IMM = 2'd1, RWS_MEM = 2'd2} reg_wsrc_e;

  typedef enum logic [2:0] {
    PCM_STEP, PCM_ABS, PCM_COND, PCM_REL, PCM_ACC, PCM_HOLD
  } pc_mode_e;

  // index into the flag vector {eq, c, ov, z}
  typedef enum logic [1:0] {CND_Z = 2'd0, CND_OV = 2'd1, CND_C = 2'd2, CND_EQ = 2'd3} cond_e;

  typedef enum logic [1:0] {STK_NONE, STK_PUSH, STK_POP} stk_op_e;

  typedef enum logic [1:0] {ADR_NONE, ADR_OPND, ADR_ACC, ADR_STACK} adr_sel_e;

  typedef struct packed {
    alu_op_e           alu_op;
    alu_src_e          alu_src;
    logic              acc_we;
    logic [RSEL_W-1:0] rd_sel;
    logic              reg_we;
    logic [RSEL_W-1:0] wr_sel;
    reg_wsrc_e         wr_src;
    logic [2:0]        flag_clr;
    logic              mem_rd;
    logic              mem_wr;
    adr_sel_e          adr_sel;
    pc_mode_e          pc_mode;
    cond_e             cond;
    stk_op_e           stk_op;
  } ctrl_t;

  localparam logic [CODE_W-1:0] C_ADD_R  = 6'h00, C_ADD_M  = 6'h01, C_ADD_I  = 6'h02;
  localparam logic [CODE_W-1:0] C_SUB_R  = 6'h03, C_SUB_M  = 6'h04, C_SUB_I  = 6'h05;
  localparam logic [CODE_W-1:0] C_INC    = 6'h06, C_DEC    = 6'h07;
  localparam logic [CODE_W-1:0] C_SRA    = 6'h08, C_SLA    = 6'h09, C_SLL    = 6'h0A;
  localparam logic [CODE_W-1:0] C_SRL    = 6'h0B, C_RRC    = 6'h0C, C_RLC    = 6'h0D;
  localparam logic [CODE_W-1:0] C_AND_R  = 6'h0E, C_OR_R   = 6'h0F, C_XOR_R  = 6'h10;
  localparam logic [CODE_W-1:0] C_NOT    = 6'h11, C_NEG    = 6'h12;
  localparam logic [CODE_W-1:0] C_JMP    = 6'h13, C_JZ     = 6'h14, C_JOV    = 6'h15;
  localparam logic [CODE_W-1:0] C_JC     = 6'h16, C_JREL   = 6'h17, C_JEQ    = 6'h18;
  localparam logic [CODE_W-1:0] C_CLRZ   = 6'h19, C_CLROV  = 6'h1A, C_CLRC   = 6'h1B;
  localparam logic [CODE_W-1:0] C_CLRA   = 6'h1C, C_PC_LD  = 6'h1D, C_PC_SV  = 6'h1E;
  localparam logic [CODE_W-1:0] C_LDA_M  = 6'h1F, C_STA_M  = 6'h20, C_LDR0_I = 6'h21;
  localparam logic [CODE_W-1:0] C_LDR0_M = 6'h22, C_LDA_R  = 6'h23, C_STA_R  = 6'h24;
  localparam logic [CODE_W-1:0] C_LDA_IX = 6'h25;
  localparam logic [CODE_W-1:0] C_PUSH   = 6'h3C, C_POP    = 6'h3D, C_NOP    = 6'h3E;
  localparam logic [CODE_W-1:0] C_HALT   = 6'h3F;

endpackage

// File: rtl/acc_ctrl_decode.sv
module acc_ctrl_decode
  import acc_ctrl_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [RSEL_W-1:0] opnd_sel_i,
  output ctrl_t             ctrl_o
);

  // accumulator-writing ALU operation with a chosen source
  function automatic ctrl_t acc_op(input ctrl_t base, input alu_op_e op, input alu_src_e src);
    ctrl_t c;
    c         = base;
    c.alu_op  = op;
    c.alu_src = src;
    c.acc_we  = 1'b1;
    return c;
  endfunction

  ctrl_t idle;

  always_comb begin
    idle          = '0;
    idle.alu_op   = ALU_HOLD;
    idle.alu_src  = SRC_NONE;
    idle.wr_src   = RWS_ACC;
    idle.adr_sel  = ADR_NONE;
    idle.pc_mode  = PCM_STEP;
    idle.cond     = CND_Z;
    idle.stk_op   = STK_NONE;

    ctrl_o = idle;
    unique case (code_i)
      C_ADD_R:  begin ctrl_o = acc_op(idle, ALU_ADD, SRC_REG); ctrl_o.rd_sel = opnd_sel_i; end
      C_ADD_M:  begin ctrl_o = acc_op(idle, ALU_ADD, SRC_MEM); ctrl_o.mem_rd = 1'b1; ctrl_o.adr_sel = ADR_OPND; end
      C_ADD_I:  ctrl_o = acc_op(idle, ALU_ADD, SRC_IMM);
      C_SUB_R:  begin ctrl_o = acc_op(idle, ALU_SUB, SRC_REG); ctrl_o.rd_sel = opnd_sel_i; end
      C_SUB_M:  begin ctrl_o = acc_op(idle, ALU_SUB, SRC_MEM); ctrl_o.mem_rd = 1'b1; ctrl_o.adr_sel = ADR_OPND; end
      C_SUB_I:  ctrl_o = acc_op(idle, ALU_SUB, SRC_IMM);
      C_INC:    ctrl_o = acc_op(idle, ALU_INC, SRC_NONE);
      C_DEC:    ctrl_o = acc_op(idle, ALU_DEC, SRC_NONE);
      C_SRA:    ctrl_o = acc_op(idle, ALU_SRA, SRC_NONE);
      C_SLA:    ctrl_o = acc_op(idle, ALU_SLA, SRC_NONE);
      C_SLL:    ctrl_o = acc_op(idle, ALU_SLL, SRC_NONE);
      C_SRL:    ctrl_o = acc_op(idle, ALU_SRL, SRC_NONE);
      C_RRC:    ctrl_o = acc_op(idle, ALU_RRC, SRC_NONE);
      C_RLC:    ctrl_o = acc_op(idle, ALU_RLC, SRC_NONE);
      C_AND_R:  begin ctrl_o = acc_op(idle, ALU_AND, SRC_REG); ctrl_o.rd_sel = opnd_sel_i; end
      C_OR_R:   begin ctrl_o = acc_op(idle, ALU_OR,  SRC_REG); ctrl_o.rd_sel = opnd_sel_i; end
      C_XOR_R:  begin ctrl_o = acc_op(idle, ALU_XOR, SRC_REG); ctrl_o.rd_sel = opnd_sel_i; end
      C_NOT:    ctrl_o = acc_op(idle, ALU_NOT, SRC_NONE);
      C_NEG:    ctrl_o = acc_op(idle, ALU_NEG, SRC_NONE);
      C_JMP:    ctrl_o.pc_mode = PCM_ABS;
      C_JZ:     begin ctrl_o.pc_mode = PCM_COND; ctrl_o.cond = CND_Z;  end
      C_JOV:    begin ctrl_o.pc_mode = PCM_COND; ctrl_o.cond = CND_OV; end
      C_JC:     begin ctrl_o.pc_mode = PCM_COND; ctrl_o.cond = CND_C;  end
      C_JEQ:    begin ctrl_o.pc_mode = PCM_COND; ctrl_o.cond = CND_EQ; end
      C_JREL:   ctrl_o.pc_mode = PCM_REL;
      C_CLRZ:   ctrl_o.flag_clr = 3'b001;
      C_CLROV:  ctrl_o.flag_clr = 3'b010;
      C_CLRC:   ctrl_o.flag_clr = 3'b100;
      C_CLRA:   ctrl_o = acc_op(idle, ALU_CLR, SRC_NONE);
      C_PC_LD:  ctrl_o.pc_mode = PCM_ACC;
      C_PC_SV:  ctrl_o = acc_op(idle, ALU_PASS, SRC_PC);
      C_LDA_M:  begin ctrl_o = acc_op(idle, ALU_PASS, SRC_MEM); ctrl_o.mem_rd = 1'b1; ctrl_o.adr_sel = ADR_OPND; end
      C_STA_M:  begin ctrl_o.mem_wr = 1'b1; ctrl_o.adr_sel = ADR_OPND; end
      C_LDR0_I: begin ctrl_o.reg_we = 1'b1; ctrl_o.wr_src = RWS_IMM; end
      C_LDR0_M: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.wr_src  = RWS_MEM;
        ctrl_o.mem_rd  = 1'b1;
        ctrl_o.adr_sel = ADR_OPND;
      end
      C_LDA_R:  begin ctrl_o = acc_op(idle, ALU_PASS, SRC_REG); ctrl_o.rd_sel = opnd_sel_i; end
      C_STA_R:  begin ctrl_o.reg_we = 1'b1; ctrl_o.wr_sel = opnd_sel_i; ctrl_o.wr_src = RWS_ACC; end
      C_LDA_IX: begin ctrl_o = acc_op(idle, ALU_PASS, SRC_MEM); ctrl_o.mem_rd = 1'b1; ctrl_o.adr_sel = ADR_ACC; end
      C_PUSH:   begin ctrl_o.mem_wr = 1'b1; ctrl_o.adr_sel = ADR_STACK; ctrl_o.stk_op = STK_PUSH; end
      C_POP:    begin
        ctrl_o         = acc_op(idle, ALU_PASS, SRC_MEM);
        ctrl_o.mem_rd  = 1'b1;
        ctrl_o.adr_sel = ADR_STACK;
        ctrl_o.stk_op  = STK_POP;
      end
      C_HALT:   ctrl_o.pc_mode = PCM_HOLD;
      default:  ctrl_o = idle;   // NOP and every unassigned code (R2)
    endcase
  end

endmodule

// File: rtl/acc_ctrl_pc.sv
module acc_ctrl_pc
  import acc_ctrl_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OPND_W = 32,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_mode_e          mode_i,
  input  cond_e             cond_i,
  input  logic [3:0]        flags_i,   // {eq, c, ov, z}
  input  logic [OPND_W-1:0] opnd_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              taken_o
);

  function automatic logic [PC_W-1:0] f_step(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] f_rel(input logic [PC_W-1:0] pc, input logic [OPND_W-1:0] off);
    return pc + off[PC_W-1:0];
  endfunction

  logic [PC_W-1:0] pc_q, pc_nxt;

  assign taken_o = flags_i[cond_i];

  always_comb begin
    unique case (mode_i)
      PCM_ABS:  pc_nxt = opnd_i[PC_W-1:0];
      PCM_COND: pc_nxt = taken_o ? opnd_i[PC_W-1:0] : f_step(pc_q);
      PCM_REL:  pc_nxt = f_rel(pc_q, opnd_i);
      PCM_ACC:  pc_nxt = acc_i[PC_W-1:0];
      PCM_HOLD: pc_nxt = pc_q;
      default:  pc_nxt = f_step(pc_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;

  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == PCM_HOLD |=> pc_q == $past(pc_q));

  p_abs_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == PCM_ABS |=> pc_q == $past(opnd_i[PC_W-1:0]));

  p_untaken_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PCM_COND && !taken_o) |=> pc_q == f_step($past(pc_q)));

  p_acc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == PCM_ACC |=> pc_q == $past(acc_i[PC_W-1:0]));

endmodule

// File: rtl/acc_ctrl_stack.sv
module acc_ctrl_stack
  import acc_ctrl_pkg::*;
#(
  parameter int SP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  stk_op_e         op_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] sp_below_o,
  output logic            err_o,
  output logic            push_ok_o,
  output logic            pop_ok_o
);

  localparam logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}};

  logic [SP_W-1:0] sp_q;
  logic            full, empty;

  assign full       = (sp_q == SP_TOP);
  assign empty      = (sp_q == '0);
  assign push_ok_o  = (op_i == STK_PUSH) && !full;
  assign pop_ok_o   = (op_i == STK_POP)  && !empty;
  assign err_o      = ((op_i == STK_PUSH) && full) || ((op_i == STK_POP) && empty);
  assign sp_below_o = sp_q - SP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sp_q <= '0;
    else if (push_ok_o) sp_q <= sp_q + SP_W'(1);
    else if (pop_ok_o)  sp_q <= sp_below_o;
  end

  assign sp_o = sp_q;

  p_push_inc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == STK_PUSH && !err_o) |=> sp_q == $past(sp_q) + SP_W'(1));

  p_pop_dec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == STK_POP && !err_o) |=> sp_q == $past(sp_q) - SP_W'(1));

  p_err_keep_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> $stable(sp_q));

  p_idle_keep_r13: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == STK_NONE |=> $stable(sp_q));

endmodule

// File: rtl/acc_ctrl_unit.sv
module acc_ctrl_unit
  import acc_ctrl_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DA_W   = 16,
  parameter int SP_W   = 4,
  parameter int OPND_W = 32,
  parameter int ACC_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [OPND_W+OPC_W-1:0] instr_i,
  input  logic                    flag_z_i,
  input  logic                    flag_ov_i,
  input  logic                    flag_c_i,
  input  logic                    flag_eq_i,
  input  logic [ACC_W-1:0]        acc_i,
  output logic [PC_W-1:0]         pc_o,
  output logic [4:0]              alu_op_o,
  output logic [2:0]              alu_src_o,
  output logic                    acc_we_o,
  output logic [RSEL_W-1:0]       reg_rd_sel_o,
  output logic                    reg_we_o,
  output logic [RSEL_W-1:0]       reg_wr_sel_o,
  output logic [1:0]              reg_wr_src_o,
  output logic [2:0]              flag_clr_o,
  output logic [DA_W-1:0]         mem_addr_o,
  output logic                    mem_re_o,
  output logic                    mem_we_o,
  output logic [SP_W-1:0]         sp_o,
  output logic                    stack_err_o
);

  localparam int CODE_LSB = OPND_W;

  logic [CODE_W-1:0] code;
  logic [OPND_W-1:0] opnd;
  ctrl_t             ctrl;
  logic [SP_W-1:0]   sp_now, sp_below;
  logic              stk_err, push_ok, pop_ok, br_taken;

  assign code = instr_i[CODE_LSB +: CODE_W];   // bits above are reserved
  assign opnd = instr_i[OPND_W-1:0];

  acc_ctrl_decode u_dec (
    .code_i     (code),
    .opnd_sel_i (opnd[RSEL_W-1:0]),
    .ctrl_o     (ctrl)
  );

  acc_ctrl_pc #(.PC_W(PC_W), .OPND_W(OPND_W), .ACC_W(ACC_W)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (ctrl.pc_mode),
    .cond_i  (ctrl.cond),
    .flags_i ({flag_eq_i, flag_c_i, flag_ov_i, flag_z_i}),
    .opnd_i  (opnd),
    .acc_i   (acc_i),
    .pc_o    (pc_o),
    .taken_o (br_taken)
  );

  acc_ctrl_stack #(.SP_W(SP_W)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (ctrl.stk_op),
    .sp_o       (sp_now),
    .sp_below_o (sp_below),
    .err_o      (stk_err),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok)
  );

  always_comb begin
    unique case (ctrl.adr_sel)
      ADR_OPND:  mem_addr_o = opnd[DA_W-1:0];
      ADR_ACC:   mem_addr_o = acc_i[DA_W-1:0];
      ADR_STACK: mem_addr_o = stk_err ? '0 : DA_W'(push_ok ? sp_now : sp_below);
      default:   mem_addr_o = '0;
    endcase
  end

  assign alu_op_o     = ctrl.alu_op;
  assign alu_src_o    = ctrl.alu_src;
  assign acc_we_o     = ctrl.acc_we && !stk_err;
  assign reg_rd_sel_o = ctrl.rd_sel;
  assign reg_we_o     = ctrl.reg_we;
  assign reg_wr_sel_o = ctrl.wr_sel;
  assign reg_wr_src_o = ctrl.wr_src;
  assign flag_clr_o   = ctrl.flag_clr;
  assign mem_re_o     = ctrl.mem_rd && !stk_err;
  assign mem_we_o     = ctrl.mem_wr && !stk_err;
  assign sp_o         = sp_now;
  assign stack_err_o  = stk_err;

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  p_err_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err_o |-> (!mem_we_o && !mem_re_o && !acc_we_o));

  p_push_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> (mem_we_o && mem_addr_o == DA_W'(sp_o)));

  p_taken_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pc_mode == PCM_COND && br_taken) |=> pc_o == $past(opnd[PC_W-1:0]));

endmodule

// File: tb/acc_ctrl_unit_test.sv
`timescale 1ns/1ps
module acc_ctrl_unit_test;

  localparam int PC_W = 16, DA_W = 16, SP_W = 4, OPND_W = 32, ACC_W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n;
  logic [OPND_W+7:0]    instr;
  logic                 fz, fov, fc, feq;
  logic [ACC_W-1:0]     acc;
  logic [PC_W-1:0]      pc_o;
  logic [4:0]           alu_op_o;
  logic [2:0]           alu_src_o;
  logic                 acc_we_o;
  logic [2:0]           reg_rd_sel_o;
  logic                 reg_we_o;
  logic [2:0]           reg_wr_sel_o;
  logic [1:0]           reg_wr_src_o;
  logic [2:0]           flag_clr_o;
  logic [DA_W-1:0]      mem_addr_o;
  logic                 mem_re_o, mem_we_o;
  logic [SP_W-1:0]      sp_o;
  logic                 stack_err_o;

  acc_ctrl_unit #(.PC_W(PC_W), .DA_W(DA_W), .SP_W(SP_W), .OPND_W(OPND_W), .ACC_W(ACC_W)) uut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr),
    .flag_z_i(fz), .flag_ov_i(fov), .flag_c_i(fc), .flag_eq_i(feq), .acc_i(acc),
    .pc_o(pc_o), .alu_op_o(alu_op_o), .alu_src_o(alu_src_o), .acc_we_o(acc_we_o),
    .reg_rd_sel_o(reg_rd_sel_o), .reg_we_o(reg_we_o), .reg_wr_sel_o(reg_wr_sel_o),
    .reg_wr_src_o(reg_wr_src_o), .flag_clr_o(flag_clr_o), .mem_addr_o(mem_addr_o),
    .mem_re_o(mem_re_o), .mem_we_o(mem_we_o), .sp_o(sp_o), .stack_err_o(stack_err_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [PC_W-1:0] m_pc = '0;
  logic [SP_W-1:0] m_sp = '0;

  // expected values for the current instruction
  logic [4:0] e_alu; logic [2:0] e_src; logic e_awe; logic [2:0] e_rd;
  logic e_rwe; logic [2:0] e_wsel; logic [1:0] e_wsrc; logic [2:0] e_fclr;
  logic e_mre, e_mwe; logic [DA_W-1:0] e_addr; logic e_err;
  logic [PC_W-1:0] e_pc; logic [SP_W-1:0] e_sp;
  string e_req;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (instr=%0h)", req, act, exp, instr);
    end
  endtask

  function automatic void acc_load(input logic [4:0] op, input logic [2:0] src);
    e_alu = op; e_src = src; e_awe = 1'b1;
  endfunction

  task automatic model();
    logic [5:0] c;
    logic [3:0] fl;
    c = instr[OPND_W +: 6];
    fl = {feq, fc, fov, fz};
    e_alu = 5'd15; e_src = 0; e_awe = 0; e_rd = 0; e_rwe = 0; e_wsel = 0; e_wsrc = 0;
    e_fclr = 0; e_mre = 0; e_mwe = 0; e_addr = 0; e_err = 0;
    e_pc = m_pc + 16'd1; e_sp = m_sp; e_req = "R2";
    if (c <= 6'h12 || c == 6'h1C) e_req = "R3";
    case (c)
      6'h00, 6'h03, 6'h0E, 6'h0F, 6'h10: begin
        e_rd = instr[2:0];
        acc_load(c == 6'h00 ? 5'd1 : c == 6'h03 ? 5'd2 : c == 6'h0E ? 5'd3 : c == 6'h0F ? 5'd4 : 5'd5, 3'd1);
      end
      6'h01, 6'h04: begin acc_load(c == 6'h01 ? 5'd1 : 5'd2, 3'd2); e_mre = 1; e_addr = instr[15:0]; end
      6'h02, 6'h05: acc_load(c == 6'h02 ? 5'd1 : 5'd2, 3'd3);
      6'h06: acc_load(5'd16, 3'd0);
      6'h07: acc_load(5'd17, 3'd0);
      6'h08: acc_load(5'd8, 3'd0);
      6'h09: acc_load(5'd9, 3'd0);
      6'h0A: acc_load(5'd11, 3'd0);
      6'h0B: acc_load(5'd10, 3'd0);
      6'h0C: acc_load(5'd12, 3'd0);
      6'h0D: acc_load(5'd13, 3'd0);
      6'h11: acc_load(5'd6, 3'd0);
      6'h12: acc_load(5'd7, 3'd0);
      6'h1C: acc_load(5'd14, 3'd0);
      6'h13: begin e_pc = instr[15:0]; e_req = "R7"; end
      6'h17: begin e_pc = m_pc + instr[15:0]; e_req = "R7"; end
      6'h14, 6'h15, 6'h16, 6'h18: begin
        e_req = "R8";
        if (fl[c == 6'h18 ? 3 : c - 6'h14]) e_pc = instr[15:0];
      end
      6'h19: begin e_fclr = 3'b001; e_req = "R14"; end
      6'h1A: begin e_fclr = 3'b010; e_req = "R14"; end
      6'h1B: begin e_fclr = 3'b100; e_req = "R14"; end
      6'h1D: begin e_pc = acc[15:0]; e_req = "R9"; end
      6'h1E: begin acc_load(5'd0, 3'd4); e_req = "R9"; end
      6'h1F: begin acc_load(5'd0, 3'd2); e_mre = 1; e_addr = instr[15:0]; e_req = "R5"; end
      6'h20: begin e_mwe = 1; e_addr = instr[15:0]; e_req = "R6"; end
      6'h21: begin e_rwe = 1; e_wsrc = 2'd1; e_req = "R4"; end
      6'h22: begin e_rwe = 1; e_wsrc = 2'd2; e_mre = 1; e_addr = instr[15:0]; e_req = "R4"; end
      6'h23: begin acc_load(5'd0, 3'd1); e_rd = instr[2:0]; e_req = "R4"; end
      6'h24: begin e_rwe = 1; e_wsel = instr[2:0]; e_wsrc = 2'd0; e_req = "R4"; end
      6'h25: begin acc_load(5'd0, 3'd2); e_mre = 1; e_addr = acc[15:0]; e_req = "R5"; end
      6'h3C: begin
        if (m_sp == 4'hF) begin e_err = 1; e_req = "R13"; end
        else begin e_mwe = 1; e_addr = 16'(m_sp); e_sp = m_sp + 4'd1; e_req = "R11"; end
      end
      6'h3D: begin
        e_alu = 5'd0; e_src = 3'd2;
        if (m_sp == 4'h0) begin e_err = 1; e_req = "R13"; end
        else begin e_awe = 1; e_mre = 1; e_addr = 16'(m_sp - 4'd1); e_sp = m_sp - 4'd1; e_req = "R12"; end
      end
      6'h3F: begin e_pc = m_pc; e_req = "R10"; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [7:0] op8, input logic [31:0] opnd, input logic [3:0] flg, input logic [31:0] a);
    @(negedge clk);
    instr = {op8, opnd}; {feq, fc, fov, fz} = flg; acc = a;
    #1;
    model();
    check(e_req, 64'({alu_op_o, alu_src_o, acc_we_o, reg_rd_sel_o, reg_we_o, reg_wr_sel_o, reg_wr_src_o,
                      flag_clr_o, mem_re_o, mem_we_o, mem_addr_o, stack_err_o}),
                 64'({e_alu, e_src, e_awe, e_rd, e_rwe, e_wsel, e_wsrc, e_fclr, e_mre, e_mwe, e_addr, e_err}));
    @(posedge clk); #1;
    check(e_req, 64'(pc_o), 64'(e_pc));
    check(e_req, 64'(sp_o), 64'(e_sp));
    m_pc = e_pc; m_sp = e_sp;
  endtask

  function automatic logic [5:0] valid_code(input int i);
    return (i < 38) ? 6'(i) : 6'(8'h3C + i - 38);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; instr = {8'h3F, 32'h0}; {fz, fov, fc, feq} = 4'b1111; acc = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 64'(pc_o), 64'd0);
    check("R1", 64'(sp_o), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 64'(pc_o), 64'd0);   // halt held during release

    // reserved bits and unassigned codes (R2)
    step(8'hC0 | 8'h02, 32'h0000_0055, 4'h0, 32'h0);
    step(8'h3E, 32'h1234, 4'hF, 32'h0);
    step(8'h80 | 8'h2A, 32'h7, 4'h0, 32'h0);
    step(8'h40 | 8'h3B, 32'h7, 4'h0, 32'h0);
    // relative jump wrap (R7)
    step(8'h13, 32'h0000_FFF0, 4'h0, 32'h0);
    step(8'h17, 32'h0000_0020, 4'h0, 32'h0);
    step(8'h17, 32'hABCD_FFFF, 4'h0, 32'h0);
    // conditional jumps taken and not (R8)
    for (int f = 0; f < 4; f++) begin
      logic [7:0] cc;
      cc = (f == 3) ? 8'h18 : 8'(8'h14 + f);
      step(cc, 32'h0000_0100, 4'(1 << f), 32'h0);
      step(cc, 32'h0000_0200, ~4'(1 << f), 32'h0);
    end
    // accumulator-driven PC and addresses (R9, R5)
    step(8'h1D, 32'h0, 4'h0, 32'h1234_4321);
    step(8'h1E, 32'h0, 4'h0, 32'h0);
    step(8'h25, 32'h0, 4'h0, 32'hDEAD_BEEF);
    // halt holds (R10)
    step(8'h3F, 32'h55, 4'hF, 32'h9);
    step(8'h3F, 32'h55, 4'hF, 32'h9);
    // fill stack then overflow (R11, R13)
    for (int i = 0; i < 16; i++) step(8'h3C, 32'h0, 4'h0, 32'(i));
    step(8'h3C, 32'h0, 4'h0, 32'h0);
    // drain stack then underflow (R12, R13)
    for (int i = 0; i < 16; i++) step(8'h3D, 32'h0, 4'h0, 32'h0);
    step(8'h3D, 32'h0, 4'h0, 32'h0);
    // flag clears and store (R14, R6)
    step(8'h19, 32'h0, 4'h0, 32'h0);
    step(8'h1A, 32'h0, 4'h0, 32'h0);
    step(8'h1B, 32'h0, 4'h0, 32'h0);
    step(8'h20, 32'h0000_4567, 4'h0, 32'h0);
    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] op;
      int r;
      r = $urandom % 100;
      if (r < 8) op = 8'($urandom);
      else if (r < 30) op = {2'($urandom), (r < 19) ? 6'h3C : 6'h3D};
      else op = {2'($urandom), valid_code($urandom % 42)};
      step(op, $urandom, 4'($urandom), $urandom);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule